// File: doc/BRIEF.md
# FSK Tone Generator with Recurrence Oscillator

This block turns one serial data line into a binary frequency-shift-keyed tone whose phase never jumps. A free-running divider makes a sample tick. On each tick a 16-bit phase accumulator adds the current tuning word. When that addition carries out, an 8-bit oscillator takes one step. The oscillator keeps a position and a velocity. It is a restoring recurrence, not a table, and it traces a sine-like wave in roughly 32 steps per period. The effective phase resolution is therefore 21 bits, and a tuning word equals 2^21 times the tone frequency divided by the tick rate.

A two-bit mode input picks the pair of mark and space words for one of four common low-speed modem channel plans. The data line picks mark or space afresh on every tick. The oscillator position is shifted to unsigned form by adding half scale. It then drives a first-order pulse-density converter, whose one-bit output goes to an external low-pass filter. Framing, bit timing and the analog path belong to the surrounding system.

Top module: `fsk_tone_gen`

## Requirements
- R1: While reset is held, and after it is released until the first tick, sineOut reads 0xFC (position -4) and pdmOut is 0. The hidden velocity starts at -8 (0xF8), the phase accumulator starts at 0 and the converter accumulator starts at 0.
- R2: A tick occurs every TICK_DIV clock cycles. The first tick falls on the TICK_DIV-th rising edge after reset is released. Between ticks, sineOut and pdmOut do not change.
- R3: On a tick, the registered tuning word is added to the 16-bit phase accumulator, modulo 2^16. The oscillator steps only when this addition carries out of bit 15; otherwise position and velocity hold.
- R4: On an oscillator step, the velocity first becomes velocity+1 if position bit 7 is set, or velocity-1 if it is clear. The position then becomes position plus the new velocity. All arithmetic is 8-bit two's complement with wraparound.
- R5: Tuning words by modeSel, written as mark/space: 0 gives 0x22B7/0x3815 (1300/2100 Hz); 1 gives 0x0A6A/0x0C04 (390/450 Hz); 2 gives 0x21EA/0x1C93 (1270/1070 Hz); 3 gives 0x3B6B/0x3614 (2225/2025 Hz).
- R6: dataIn = 1 selects the mark word and dataIn = 0 selects the space word. The choice is sampled whole into the tuning register at every tick, and the phase accumulator uses it from the next tick on.
- R7: After reset the tuning register holds 0x3815 (2100 Hz). It keeps loading 0x3815 at each tick until dataIn is sampled low at a tick, whatever modeSel is. Only a new reset restores this state.
- R8: On each tick, pdmOut becomes the carry out of adding (position + 128) mod 256 into an 8-bit accumulator. The position used is the one held before that tick's oscillator step.
- R9: A change of mode or data never clears the phase accumulator, the oscillator or the converter accumulator, so the tone stays phase-continuous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Serial data: 1 = mark, 0 = space |
| modeSel | input | 2 | Channel plan select (see R5) |
| sineOut | output | 8 | Oscillator position, two's complement |
| pdmOut | output | 1 | Pulse-density modulated output bit |

## Verification
The hardest situation to reach from the ports is a tuning word that changes on the same tick as an accumulator carry, with the oscillator mid-swing. A wrong latency or a cleared register would only show as a slow drift in phase. To get there, the stimulus toggles data on every tick and switches mode every few ticks without reset. A tick-accurate arithmetic model runs alongside and checks both outputs on every tick. Reset is also reapplied after data has been low, which shows that the 2100 Hz start state is restored.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int TUNE_W = 16;

  localparam logic [TUNE_W-1:0] WORD_IDLE = 16'h3815;

  typedef enum logic [1:0] {
    PLAN_HD1200  = 2'd0,
    PLAN_SLOW_OR = 2'd1,
    PLAN_LS_ORIG = 2'd2,
    PLAN_LS_ANS  = 2'd3
  } chanPlan_e;

  typedef struct packed {
    logic              tick;
    logic [TUNE_W-1:0] tuneWord;
  } ctrlStrobe_t;

  function automatic logic [TUNE_W-1:0] markWord(input chanPlan_e plan);
    case (plan)
      PLAN_HD1200:  markWord = 16'h22B7;
      PLAN_SLOW_OR: markWord = 16'h0A6A;
      PLAN_LS_ORIG: markWord = 16'h21EA;
      default:      markWord = 16'h3B6B;
    endcase
  endfunction

  function automatic logic [TUNE_W-1:0] spaceWord(input chanPlan_e plan);
    case (plan)
      PLAN_HD1200:  spaceWord = 16'h3815;
      PLAN_SLOW_OR: spaceWord = 16'h0C04;
      PLAN_LS_ORIG: spaceWord = 16'h1C93;
      default:      spaceWord = 16'h3614;
    endcase
  endfunction
endpackage

// File: rtl/fsk_ctrl.sv
module fsk_ctrl
  import fsk_pkg::*;
#(
  parameter int TICK_DIV = 163
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dataIn,
  input  chanPlan_e   plan,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0]  divCnt;
  logic              tickNow;
  logic              armed;
  logic              armNext;
  logic [TUNE_W-1:0] tuneReg;
  logic [TUNE_W-1:0] wordSel;

  assign tickNow = (divCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst)          divCnt <= '0;
    else if (tickNow) divCnt <= '0;
    else              divCnt <= divCnt + CNT_W'(1);
  end

  assign armNext = armed | ~dataIn;

  always_comb begin
    if (!armNext)    wordSel = WORD_IDLE;
    else if (dataIn) wordSel = markWord(plan);
    else             wordSel = spaceWord(plan);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      tuneReg <= WORD_IDLE;
    end else if (tickNow) begin
      armed   <= armNext;
      tuneReg <= wordSel;
    end
  end

  assign strobe.tick     = tickNow;
  assign strobe.tuneWord = tuneReg;

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tickNow |=> !tickNow);
  p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
    divCnt <= CNT_LAST);
  p_arm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
  p_idle_word_r7: assert property (@(posedge clk) disable iff (rst)
    !armed |-> tuneReg == WORD_IDLE);
  p_word_between_ticks_r6: assert property (@(posedge clk) disable iff (rst)
    !tickNow |=> $stable(tuneReg));
endmodule

// File: rtl/fsk_datapath.sv
module fsk_datapath
  import fsk_pkg::*;
#(
  parameter int OSC_W = 8,
  parameter int POS_INIT = -4,
  parameter int VEL_INIT = -8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  output logic [OSC_W-1:0] sineOut,
  output logic             pdmOut
);
  localparam logic [OSC_W-1:0] HALF_SCALE = OSC_W'(1) << (OSC_W - 1);
  localparam logic [OSC_W-1:0] POS_RST    = OSC_W'(POS_INIT);
  localparam logic [OSC_W-1:0] VEL_RST    = OSC_W'(VEL_INIT);

  logic [TUNE_W-1:0] phaseAcc;
  logic [TUNE_W:0]   phaseSum;
  logic              stepCarry;
  logic [OSC_W-1:0]  posReg, velReg, velStep;
  logic [OSC_W-1:0]  dacAcc;
  logic [OSC_W:0]    dacSum;

  assign phaseSum  = {1'b0, phaseAcc} + {1'b0, strobe.tuneWord};
  assign stepCarry = phaseSum[TUNE_W];
  assign velStep   = posReg[OSC_W-1] ? velReg + OSC_W'(1) : velReg - OSC_W'(1);
  assign dacSum    = {1'b0, dacAcc} + {1'b0, posReg ^ HALF_SCALE};

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      posReg   <= POS_RST;
      velReg   <= VEL_RST;
      dacAcc   <= '0;
      pdmOut   <= 1'b0;
    end else if (strobe.tick) begin
      phaseAcc <= phaseSum[TUNE_W-1:0];
      dacAcc   <= dacSum[OSC_W-1:0];
      pdmOut   <= dacSum[OSC_W];
      if (stepCarry) begin
        velReg <= velStep;
        posReg <= posReg + velStep;
      end
    end
  end

  assign sineOut = posReg;

  p_hold_off_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.tick |=> $stable(posReg) && $stable(velReg) && $stable(phaseAcc) && $stable(pdmOut));
  p_hold_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && !stepCarry) |=> $stable(posReg) && $stable(velReg));
  p_phase_advance_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.tick |=> phaseAcc == $past(phaseAcc) + $past(strobe.tuneWord));
  p_vel_down_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && stepCarry && !posReg[OSC_W-1]) |=> velReg == $past(velReg) - OSC_W'(1));
  p_vel_up_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && stepCarry && posReg[OSC_W-1]) |=> velReg == $past(velReg) + OSC_W'(1));
  p_pos_move_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && stepCarry) |=> posReg == $past(posReg) + velReg);
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_pkg::*;
#(
  parameter int TICK_DIV = 163,
  parameter int OSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dataIn,
  input  logic [1:0]       modeSel,
  output logic [OSC_W-1:0] sineOut,
  output logic             pdmOut
);
  ctrlStrobe_t strobe;
  chanPlan_e   plan;

  assign plan = chanPlan_e'(modeSel);

  fsk_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .plan   (plan),
    .strobe (strobe)
  );

  fsk_datapath #(.OSC_W(OSC_W)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sineOut (sineOut),
    .pdmOut  (pdmOut)
  );
endmodule

// File: tb/fsk_tone_gen_bench.sv
module fsk_tone_gen_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataIn = 1'b1;
  logic [1:0] modeSel = 2'd0;
  logic [7:0] sineOut;
  logic       pdmOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mPhase, mTune;
  logic [7:0]  mPos, mVel, mDac;
  logic        mPdm, mArmed;

  always #4 clk = ~clk;

  fsk_tone_gen #(.TICK_DIV(DIV)) u_fsk_tone_gen (
    .clk(clk), .rst(rst), .dataIn(dataIn), .modeSel(modeSel),
    .sineOut(sineOut), .pdmOut(pdmOut)
  );

  function automatic logic [15:0] expMark(input logic [1:0] m);
    case (m)
      2'd0: return 16'h22B7;
      2'd1: return 16'h0A6A;
      2'd2: return 16'h21EA;
      default: return 16'h3B6B;
    endcase
  endfunction

  function automatic logic [15:0] expSpace(input logic [1:0] m);
    case (m)
      2'd0: return 16'h3815;
      2'd1: return 16'h0C04;
      2'd2: return 16'h1C93;
      default: return 16'h3614;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic modelReset();
    mPhase = 16'h0000; mTune = 16'h3815; mPos = 8'hFC; mVel = 8'hF8;
    mDac = 8'h00; mPdm = 1'b0; mArmed = 1'b0;
  endtask

  task automatic modelTick();
    logic [16:0] ps;
    logic [8:0]  ds;
    ps = {1'b0, mPhase} + {1'b0, mTune};
    mPhase = ps[15:0];
    ds = {1'b0, mDac} + {1'b0, mPos + 8'd128};
    mDac = ds[7:0];
    mPdm = ds[8];
    if (ps[16]) begin
      mVel = mPos[7] ? mVel + 8'd1 : mVel - 8'd1;
      mPos = mPos + mVel;
    end
    mArmed = mArmed | ~dataIn;
    mTune = !mArmed ? 16'h3815 : (dataIn ? expMark(modeSel) : expSpace(modeSel));
  endtask

  // Runs n ticks; checks a mid-tick cycle for stability and the tick result.
  task automatic runTicks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] prevSine;
      logic       prevPdm;
      prevSine = sineOut;
      prevPdm  = pdmOut;
      @(posedge clk); #1;
      if (i % 16 == 0) begin
        chk(sineOut == prevSine, "R2 sine stable between ticks", sineOut, prevSine);
        chk(pdmOut == prevPdm, "R2 pdm stable between ticks", pdmOut, prevPdm);
      end
      repeat (DIV - 1) @(posedge clk);
      modelTick();
      #1;
      chk(sineOut == mPos, {tag, " R4 oscillator (R3 carry gating)"}, sineOut, mPos);
      chk(pdmOut == mPdm, {tag, " R8 pdm carry"}, pdmOut, mPdm);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    modelReset();
    chk(sineOut == 8'hFC, "R1 reset position", sineOut, 8'hFC);
    chk(pdmOut == 1'b0, "R1 reset pdm", pdmOut, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modeSel = 2'd1;
    dataIn = 1'b1;
    doReset();
    // R7: mark held high from reset must still give the 2100 Hz word
    runTicks(300, "R7 idle tone");
    // R6: first low arms the selector
    dataIn = 1'b0;
    runTicks(150, "R6 space after arm");
    // R5: sweep every plan with both data values
    for (int m = 0; m < 4; m++) begin
      for (int d = 1; d >= 0; d--) begin
        modeSel = 2'(m);
        dataIn = d[0];
        runTicks(350, "R5 plan sweep");
      end
    end
    // R6: data toggles every tick
    for (int i = 0; i < 200; i++) begin
      dataIn = ~dataIn;
      runTicks(1, "R6 per-tick data");
    end
    // R9: mode changes mid-tone without any register clearing
    for (int i = 0; i < 120; i++) begin
      modeSel = 2'((i / 3) % 4);
      dataIn = i[1];
      runTicks(1, "R9 continuity");
    end
    // R7: reset after arming restores the idle word
    modeSel = 2'd3;
    dataIn = 1'b1;
    doReset();
    runTicks(200, "R7 idle after re-reset");
    dataIn = 1'b0;
    runTicks(100, "R7 arm after re-reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule